// File: doc/BRIEF.md
# ESF Bit-Oriented Message Transmitter

This block produces the data-link (DL) bit for a T1/J1 extended-superframe transmitter while a bit-oriented message is in use. Software writes a 6-bit message code. While that code is anything other than all ones, the block sends a 16-bit message word over and over. It sends one bit each time the framer raises its DL strobe, leftmost bit first. The six code bits sit inside a fixed frame of eight leading ones and two zero separators.

Writing the all-ones code ends the message. First the word already under way is completed. Then a disable word is sent sixteen times, and its value depends on the line mode. After that the DL is handed back to the HDLC source. An output pulse tells the HDLC side when one of its bits has been consumed.

A small arbiter picks the DL bit on every strobe. The yellow alarm wins over everything. The message and disable words come next, and HDLC data fills the DL otherwise. Outside ESF mode the block does nothing but pass HDLC data through. Superframe timing and F-bit placement belong to the framer around this block.

Top module: `esf_bom_tx`

## Requirements
- R1: After reset the held code is all ones, `busy` is low, `dl_bit` equals `hdlc_bit`, and a strobe raises `hdlc_take`.
- R2: The message word is 16 bits: eight ones, a zero, the code bits C5 down to C0, then a zero. It is sent leftmost bit first, one bit per `dl_strobe`.
- R3: While the held code is not all ones, the message word is sent back to back with no gap between words. The first word starts two clocks after the code write.
- R4: A code written part way through a word does not alter that word. The new code is used from the next word boundary.
- R5: After the all-ones code is written, the word under way finishes unchanged and the disable pattern follows directly.
- R6: The disable word is 0xFFFF when `j1_mode`=0 (T1) and 0xFF7E when `j1_mode`=1 (J1), leftmost bit first.
- R7: Exactly 16 disable words are sent. The strobe that follows the last of them takes an HDLC bit (`hdlc_take`=1, `dl_bit`=`hdlc_bit`).
- R8: In ESF mode, `yellow_req`=1 drives `yellow_bit` onto `dl_bit` and no HDLC bit is taken. The message sequence keeps stepping on each strobe, so when the alarm is removed word alignment is unchanged.
- R9: While `busy` is high, `hdlc_take` stays low and `dl_bit` carries the message or disable bits.
- R10: With `esf_mode`=0, `dl_bit` follows `hdlc_bit` and every strobe raises `hdlc_take`. One clock after `esf_mode` goes low, `busy` is low.
- R11: `busy` rises when the first message word starts. It stays high through the last bit of the 16th disable word and is low one clock after that bit's strobe.
- R12: A code other than all ones, written while disable words are being sent, restarts the message at the next word boundary. The disable count starts again from zero the next time the message stops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| esf_mode | input | 1 | 1 = ESF framing active, 0 = HDLC pass-through |
| j1_mode | input | 1 | Disable-word choice: 0 = T1, 1 = J1 |
| code_wr | input | 1 | Write strobe for `code_in` |
| code_in | input | 6 | Message code (all ones = stop) |
| dl_strobe | input | 1 | One-clock pulse marking a DL bit slot |
| hdlc_bit | input | 1 | Next bit offered by the HDLC source |
| yellow_req | input | 1 | Yellow alarm owns the DL |
| yellow_bit | input | 1 | Yellow alarm bit for this slot |
| dl_bit | output | 1 | Bit for the current DL slot |
| hdlc_take | output | 1 | HDLC bit consumed on this strobe |
| busy | output | 1 | Message or disable words in progress |

## Verification
The yellow alarm and the message sequence compete for the same DL slot. The bench raises the alarm for one full message word. It expects every bit in that word to be the alarm bit with no HDLC bit consumed. The word that follows must be the intact message word, which shows that the sequence kept stepping underneath the alarm. Code writes are also placed in the middle of message and disable words, and the bench checks that each switch happens only at a word boundary.

// File: rtl/bomtx_pkg.sv
// Shared types for the ESF bit-oriented message transmitter.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package bomtx_pkg;

    // Sequencer phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_DIS  = 2'd2
    } bom_state_e;

    // Owner of the DL slot chosen by the arbiter
    typedef enum logic [1:0] {
        SRC_HDLC   = 2'd0,
        SRC_BOM    = 2'd1,
        SRC_YELLOW = 2'd2
    } dl_src_e;

endpackage

// File: rtl/bom_code_hold.sv
// Holds the last message code written by software and flags the stop code.
// Assumes: code_wr is a single-cycle write qualifier; reset value is stop.
module bom_code_hold #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q,
    output logic              code_stop
);

    // Capture a new code on each write; reset leaves the stop code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '1;
        end else if (code_wr) begin
            code_q <= code_in;
        end
    end

    // All ones requests the end of the message
    always_comb begin
        code_stop = &code_q;
    end

    // Written value is visible on the next cycle (R4 relies on the held copy)
    assert_code_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_wr |=> (code_q == $past(code_in)));

endmodule

// File: rtl/bom_sequencer.sv
// Steps through message and disable words, one bit per DL strobe.
// Assumes: strobe is a one-clock pulse; enable low returns to idle at once;
// the held code is read only at word boundaries.
module bom_sequencer
    import bomtx_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int DIS_REPEATS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              j1_mode,
    input  logic [CODE_W-1:0] code,
    input  logic              code_stop,
    input  logic              strobe,
    output logic              bom_bit,
    output logic              busy
);

    localparam int WORD_W = CODE_W + 10;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int REP_W  = $clog2(DIS_REPEATS + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(DIS_REPEATS - 1);

    bom_state_e        state_q;
    logic [WORD_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;
    logic [REP_W-1:0]  rep_q;
    logic              word_end;

    // Message word: eight ones, zero, code, zero
    function automatic logic [WORD_W-1:0] msg_word(input logic [CODE_W-1:0] c);
        return {8'hFF, 1'b0, c, 1'b0};
    endfunction

    // Disable word: all ones for T1, low byte 0x7E for J1
    function automatic logic [WORD_W-1:0] dis_word(input logic j1);
        logic [WORD_W-1:0] w;
        w = '1;
        if (j1) begin
            w[7:0] = 8'h7E;
        end
        return w;
    endfunction

    // Last bit of the current word leaves on this strobe
    always_comb begin
        word_end = strobe && (idx_q == IDX_LAST);
    end

    // Phase, shift register, bit index and disable repeat count
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= ST_IDLE;
            shift_q <= '1;
            idx_q   <= '0;
            rep_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!code_stop) begin
                        state_q <= ST_MSG;
                        shift_q <= msg_word(code);
                        idx_q   <= '0;
                    end
                end
                ST_MSG: begin
                    if (word_end) begin
                        idx_q <= '0;
                        if (!code_stop) begin
                            shift_q <= msg_word(code);
                        end else begin
                            state_q <= ST_DIS;
                            shift_q <= dis_word(j1_mode);
                            rep_q   <= '0;
                        end
                    end else if (strobe) begin
                        idx_q   <= idx_q + 1'b1;
                        shift_q <= {shift_q[WORD_W-2:0], 1'b1};
                    end
                end
                ST_DIS: begin
                    if (word_end) begin
                        idx_q <= '0;
                        if (!code_stop) begin
                            state_q <= ST_MSG;
                            shift_q <= msg_word(code);
                        end else if (rep_q == REP_LAST) begin
                            state_q <= ST_IDLE;
                            shift_q <= '1;
                        end else begin
                            rep_q   <= rep_q + 1'b1;
                            shift_q <= dis_word(j1_mode);
                        end
                    end else if (strobe) begin
                        idx_q   <= idx_q + 1'b1;
                        shift_q <= {shift_q[WORD_W-2:0], 1'b1};
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Leftmost remaining bit is the one offered for this slot
    always_comb begin
        bom_bit = shift_q[WORD_W-1];
        busy    = (state_q != ST_IDLE);
    end

    // Bit index moves only on a strobe (R4: words are never cut short)
    assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && enable) |=> (idx_q == $past(idx_q)));

    // Leaving the disable phase for idle only after the final repeat (R7)
    assert_dis_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(enable)) |-> ($past(rep_q) == REP_LAST && $past(word_end)));

    // Repeat counter never runs past the configured count (R7)
    assert_rep_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q <= REP_LAST);

endmodule

// File: rtl/bom_dl_arbiter.sv
// Chooses the owner of each DL slot: yellow alarm, then message, then HDLC.
// Assumes: outside ESF mode the HDLC source owns every slot.
module bom_dl_arbiter
    import bomtx_pkg::*;
(
    input  logic esf_mode,
    input  logic yellow_req,
    input  logic yellow_bit,
    input  logic bom_busy,
    input  logic bom_bit,
    input  logic hdlc_bit,
    input  logic strobe,
    output logic dl_bit,
    output logic hdlc_take
);

    dl_src_e src;

    // Fixed priority selection of the slot owner
    always_comb begin
        if (!esf_mode) begin
            src = SRC_HDLC;
        end else if (yellow_req) begin
            src = SRC_YELLOW;
        end else if (bom_busy) begin
            src = SRC_BOM;
        end else begin
            src = SRC_HDLC;
        end
    end

    // Route the chosen bit and report HDLC consumption
    always_comb begin
        unique case (src)
            SRC_YELLOW: dl_bit = yellow_bit;
            SRC_BOM:    dl_bit = bom_bit;
            default:    dl_bit = hdlc_bit;
        endcase
        hdlc_take = strobe && (src == SRC_HDLC);
    end

    // HDLC never gets the slot while message or disable words run (R9)
    always_comb begin
        assert_hdlc_blocked_R9: assert (!(hdlc_take && esf_mode && bom_busy));
    end

endmodule

// File: rtl/esf_bom_tx.sv
// ESF bit-oriented message transmitter top: code holder, word sequencer,
// DL slot arbiter.
// Assumes: dl_strobe marks each DL bit slot for one clock; the framer places
// dl_bit into the superframe.
module esf_bom_tx #(
    parameter int CODE_W      = 6,
    parameter int DIS_REPEATS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              esf_mode,
    input  logic              j1_mode,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_in,
    input  logic              dl_strobe,
    input  logic              hdlc_bit,
    input  logic              yellow_req,
    input  logic              yellow_bit,
    output logic              dl_bit,
    output logic              hdlc_take,
    output logic              busy
);

    logic [CODE_W-1:0] code_q;
    logic              code_stop;
    logic              bom_bit;

    bom_code_hold #(.CODE_W(CODE_W)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_wr   (code_wr),
        .code_in   (code_in),
        .code_q    (code_q),
        .code_stop (code_stop)
    );

    bom_sequencer #(.CODE_W(CODE_W), .DIS_REPEATS(DIS_REPEATS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (esf_mode),
        .j1_mode   (j1_mode),
        .code      (code_q),
        .code_stop (code_stop),
        .strobe    (dl_strobe),
        .bom_bit   (bom_bit),
        .busy      (busy)
    );

    bom_dl_arbiter u_arb (
        .esf_mode   (esf_mode),
        .yellow_req (yellow_req),
        .yellow_bit (yellow_bit),
        .bom_busy   (busy),
        .bom_bit    (bom_bit),
        .hdlc_bit   (hdlc_bit),
        .strobe     (dl_strobe),
        .dl_bit     (dl_bit),
        .hdlc_take  (hdlc_take)
    );

    // Yellow alarm owns the DL in ESF mode (R8)
    assert_yellow_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (esf_mode && yellow_req) |-> (dl_bit == yellow_bit && !hdlc_take));

    // Outside ESF the HDLC bit passes straight through (R10)
    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !esf_mode |-> (dl_bit == hdlc_bit && hdlc_take == dl_strobe));

    // Leaving ESF drops busy on the following clock (R10)
    assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !esf_mode |=> !busy);

endmodule

// File: tb/tb_esf_bom_tx.sv
module tb_esf_bom_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       esf_mode = 1'b1;
    logic       j1_mode = 1'b0;
    logic       code_wr = 1'b0;
    logic [5:0] code_in = 6'h3F;
    logic       dl_strobe = 1'b0;
    logic       hdlc_bit = 1'b0;
    logic       yellow_req = 1'b0;
    logic       yellow_bit = 1'b0;
    logic       dl_bit, hdlc_take, busy;

    int checks = 0;
    int fails  = 0;

    logic [15:0] acc;
    logic        any_take;
    logic        last_busy;

    esf_bom_tx dut (
        .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .j1_mode(j1_mode),
        .code_wr(code_wr), .code_in(code_in), .dl_strobe(dl_strobe),
        .hdlc_bit(hdlc_bit), .yellow_req(yellow_req), .yellow_bit(yellow_bit),
        .dl_bit(dl_bit), .hdlc_take(hdlc_take), .busy(busy)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_msg(input logic [5:0] c);
        return {8'hFF, 1'b0, c, 1'b0};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_code(input logic [5:0] c);
        @(negedge clk);
        code_in = c;
        code_wr = 1'b1;
        @(posedge clk);
        #1 code_wr = 1'b0;
    endtask

    // One DL slot: strobe for one clock, sample mid-cycle
    task automatic send_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dl_strobe = 1'b1;
            #2;
            acc       = {acc[14:0], dl_bit};
            any_take  = any_take | hdlc_take;
            last_busy = busy;
            @(posedge clk);
            #1 dl_strobe = 1'b0;
        end
    endtask

    task automatic word_start();
        acc = '0;
        any_take = 1'b0;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", busy, 0);
        hdlc_bit = 1'b1;
        #1 chk(dl_bit == 1'b1, "R1 passthru", dl_bit, 1);
        hdlc_bit = 1'b0;
        word_start();
        send_bits(1);
        chk(acc[0] == 1'b0 && any_take, "R1 take", {acc[0], any_take}, 1);
    endtask

    task automatic t_basic();
        hdlc_bit = 1'b0;
        wr_code(6'h12);
        @(posedge clk); #1;
        chk(busy == 1'b1, "R11 busy rise", busy, 1);
        for (int w = 0; w < 2; w++) begin
            word_start();
            send_bits(16);
            chk(acc == exp_msg(6'h12), "R2 R3 word", acc, exp_msg(6'h12));
            chk(!any_take, "R9 no take", any_take, 0);
        end
    endtask

    task automatic t_midword();
        word_start();
        send_bits(5);
        wr_code(6'h2D);
        send_bits(11);
        chk(acc == exp_msg(6'h12), "R4 old word", acc, exp_msg(6'h12));
        word_start();
        send_bits(16);
        chk(acc == exp_msg(6'h2D), "R4 new word", acc, exp_msg(6'h2D));
    endtask

    task automatic t_stop(input logic j1, input logic [15:0] dw);
        j1_mode = j1;
        word_start();
        send_bits(7);
        wr_code(6'h3F);
        send_bits(9);
        chk(acc == exp_msg(6'h2D), "R5 finish word", acc, exp_msg(6'h2D));
        for (int w = 0; w < 16; w++) begin
            word_start();
            send_bits(16);
            chk(acc == dw, "R6 disable word", acc, dw);
            chk(!any_take, "R9 no take dis", any_take, 0);
        end
        chk(last_busy == 1'b1, "R11 busy last bit", last_busy, 1);
        chk(busy == 1'b0, "R11 busy fall", busy, 0);
        hdlc_bit = 1'b0;
        word_start();
        send_bits(1);
        chk(any_take && acc[0] == 1'b0, "R7 handoff", {any_take, acc[0]}, 2);
    endtask

    task automatic t_yellow();
        j1_mode = 1'b0;
        hdlc_bit = 1'b1;
        wr_code(6'h2D);
        @(posedge clk); #1;
        yellow_req = 1'b1;
        yellow_bit = 1'b0;
        word_start();
        send_bits(16);
        chk(acc == 16'h0000, "R8 yellow bits", acc, 0);
        chk(!any_take, "R8 no take", any_take, 0);
        yellow_req = 1'b0;
        word_start();
        send_bits(16);
        chk(acc == exp_msg(6'h2D), "R8 alignment", acc, exp_msg(6'h2D));
    endtask

    task automatic t_restart();
        wr_code(6'h3F);
        word_start();
        send_bits(16);
        for (int w = 0; w < 2; w++) begin
            word_start();
            send_bits(16);
            chk(acc == 16'hFFFF, "R12 disable", acc, 16'hFFFF);
        end
        word_start();
        send_bits(3);
        wr_code(6'h05);
        send_bits(13);
        chk(acc == 16'hFFFF, "R12 finish disable", acc, 16'hFFFF);
        word_start();
        send_bits(16);
        chk(acc == exp_msg(6'h05), "R12 restart", acc, exp_msg(6'h05));
        chk(busy == 1'b1, "R12 busy", busy, 1);
    endtask

    task automatic t_no_esf();
        @(negedge clk);
        esf_mode = 1'b0;
        @(posedge clk); #1;
        chk(busy == 1'b0, "R10 busy", busy, 0);
        hdlc_bit = 1'b1;
        word_start();
        send_bits(1);
        chk(acc[0] == 1'b1 && any_take, "R10 pass 1", {acc[0], any_take}, 3);
        hdlc_bit = 1'b0;
        word_start();
        send_bits(1);
        chk(acc[0] == 1'b0 && any_take, "R10 pass 0", {acc[0], any_take}, 1);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_midword();
        t_stop(1'b0, 16'hFFFF);
        wr_code(6'h2D);
        @(posedge clk); #1;
        word_start();
        send_bits(16);
        t_stop(1'b1, 16'hFF7E);
        t_yellow();
        t_restart();
        t_no_esf();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule